// File: doc/BRIEF.md
# DMA Channel Event and Interrupt Hub

This block is the shared event collector of a multi-channel DMA engine. Each channel reports four kinds of event as single-cycle pulses: transfer complete, source error, destination error and configuration error. For every kind the hub keeps a sticky raw vector with one bit per channel. It also offers an enabled view of that vector, which is the raw vector ANDed with each channel's interrupt-enable bit. All enabled bits of all four kinds are ORed into one registered interrupt line.

Software reaches the hub through a plain write strobe, an address and write data, and reads it back through a combinational read port. A bit is cleared by writing a one to it at the raw address of its event kind, so one handler can acknowledge just the channels it has serviced. The same address window holds three more registers. A read-only register mirrors the per-channel busy flags. Two write-only registers hold the group priority and the arbitration setting; their values are driven out of the block to the channel arbiter.

Top module: `dma_irq_hub`

## Requirements
- R1: An event pulse on channel n of a kind sets bit n of that kind's raw vector at the next clock edge. The raw vectors read back at 0x810 (complete), 0x814 (source error), 0x818 (destination error) and 0x81C (configuration error), with bit n meaning channel n.
- R2: Reads of 0x800, 0x804, 0x808 and 0x80C return the raw vector of the same kind (same order as R1) ANDed with `ch_irq_en`. The enable mask is applied at read time.
- R3: A write to a raw address clears, at the next edge, every bit that is one in the write data. Bits written as zero keep their value. A write of all ones clears every channel.
- R4: When a clear and a new event hit the same bit in the same cycle, the bit is set after the edge.
- R5: A raw write changes only the kind it addresses; the other three raw vectors keep their contents.
- R6: `irq` equals the OR of all enabled bits of all four kinds as they stood one cycle earlier.
- R7: A read of 0x820 returns `ch_busy` as it is now, with bit n meaning channel n.
- R8: A write to 0x824 loads `grp_prio` and a write to 0x828 loads `arb_cfg`, both visible after the edge. Reads of either address return zero. A value of zero in `arb_cfg` means all channels have equal priority.
- R9: While `rst_n` is low at a clock edge, all raw vectors, `irq`, `grp_prio` and `arb_cfg` are cleared.
- R10: Writes to the enabled-view addresses 0x800..0x80C, or to any unmapped address, leave all raw vectors unchanged. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_done | input | NUM_CH | Transfer-complete pulses, one per channel |
| ev_src_err | input | NUM_CH | Source-error pulses |
| ev_dst_err | input | NUM_CH | Destination-error pulses |
| ev_cfg_err | input | NUM_CH | Configuration-error pulses |
| ch_irq_en | input | NUM_CH | Per-channel interrupt enable |
| ch_busy | input | NUM_CH | Per-channel busy flags from the datapaths |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte address of the register access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data for `addr` |
| irq | output | 1 | Combined registered interrupt |
| grp_prio | output | DATA_W | Group priority setting |
| arb_cfg | output | DATA_W | Arbitration setting, zero for equal priority |

## Verification
A corrupted raw bit becomes visible at once on a read of its raw address or its enabled-view address, and it reaches `irq` one edge later if the channel is enabled. A clear that hits the wrong kind or the wrong channel, or a wrong collision priority, therefore appears within a single cycle of the offending write. The bench reads all eight event views, the busy mirror and the control outputs after every edge. Each of these is compared with a model that is updated from the requirements alone.

// File: rtl/dma_irq_pkg.sv
`timescale 1ns/1ps
// Shared constants of the event hub: event kinds and the register map.
// Assumes a 12-bit byte address with word-aligned registers.
package dma_irq_pkg;
    localparam int ADDR_W    = 12;
    localparam int NUM_CLASS = 4;

    typedef enum logic [1:0] {
        EV_DONE    = 2'd0,
        EV_SRC_ERR = 2'd1,
        EV_DST_ERR = 2'd2,
        EV_CFG_ERR = 2'd3
    } ev_class_e;

    localparam logic [ADDR_W-1:0] VIEW_BASE = 12'h800;
    localparam logic [ADDR_W-1:0] RAW_BASE  = 12'h810;
    localparam logic [ADDR_W-1:0] BUSY_ADDR = 12'h820;
    localparam logic [ADDR_W-1:0] PRIO_ADDR = 12'h824;
    localparam logic [ADDR_W-1:0] ARB_ADDR  = 12'h828;

    // Address of the raw vector of event kind k.
    function automatic logic [ADDR_W-1:0] raw_addr(input int k);
        return RAW_BASE + ADDR_W'(4 * k);
    endfunction

    // Address of the enabled view of event kind k.
    function automatic logic [ADDR_W-1:0] view_addr(input int k);
        return VIEW_BASE + ADDR_W'(4 * k);
    endfunction
endpackage

// File: rtl/dma_irq_decode.sv
`timescale 1ns/1ps
// Write decoder: turns the write strobe and the address into one
// enable per raw vector and one per control register.
// Assumes exact address match; all other writes are dropped.
module dma_irq_decode
    import dma_irq_pkg::*;
(
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_CLASS-1:0] raw_we,
    output logic                 prio_we,
    output logic                 arb_we
);
    // Match the address against each writable register.
    always_comb begin
        for (int k = 0; k < NUM_CLASS; k++) begin
            raw_we[k] = wr_en && (addr == raw_addr(k));
        end
        prio_we = wr_en && (addr == PRIO_ADDR);
        arb_we  = wr_en && (addr == ARB_ADDR);
    end
endmodule

// File: rtl/dma_irq_class.sv
`timescale 1ns/1ps
// One event kind: a sticky raw vector with write-one-to-clear and
// its enabled view. A new event on a bit wins over a clear of that bit.
// Assumes event inputs are synchronous single-cycle pulses.
module dma_irq_class #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ev,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] clr_bits,
    input  logic [NUM_CH-1:0] en,
    output logic [NUM_CH-1:0] raw_q,
    output logic [NUM_CH-1:0] view
);
    logic [NUM_CH-1:0] clr_eff;

    // Clear mask applies only when this kind is addressed.
    always_comb clr_eff = clr_we ? clr_bits : '0;

    // Sticky raw vector: clear first, then set, so set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr_eff) | ev;
    end

    // Enabled view follows the enables without delay.
    always_comb view = raw_q & en;
endmodule

// File: rtl/dma_irq_rdmux.sv
`timescale 1ns/1ps
// Read multiplexer: returns raw vectors, enabled views and the busy
// mirror. Write-only and unmapped addresses read as zero.
// Assumes NUM_CH does not exceed DATA_W.
module dma_irq_rdmux
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0]                addr,
    input  logic [NUM_CLASS-1:0][NUM_CH-1:0] raw,
    input  logic [NUM_CLASS-1:0][NUM_CH-1:0] view,
    input  logic [NUM_CH-1:0]                busy,
    output logic [DATA_W-1:0]                rdata
);
    // Select the addressed vector, zero-extended to the bus width.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_CLASS; k++) begin
            if (addr == raw_addr(k))  rdata = DATA_W'(raw[k]);
            if (addr == view_addr(k)) rdata = DATA_W'(view[k]);
        end
        if (addr == BUSY_ADDR) rdata = DATA_W'(busy);
    end
endmodule

// File: rtl/dma_irq_hub.sv
`timescale 1ns/1ps
// Event and interrupt hub of a multi-channel DMA engine. Holds four
// kinds of per-channel events, drives one registered interrupt,
// mirrors channel busy flags and keeps the arbitration settings.
// Assumes synchronous event pulses and NUM_CH <= DATA_W.
module dma_irq_hub
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ev_done,
    input  logic [NUM_CH-1:0] ev_src_err,
    input  logic [NUM_CH-1:0] ev_dst_err,
    input  logic [NUM_CH-1:0] ev_cfg_err,
    input  logic [NUM_CH-1:0] ch_irq_en,
    input  logic [NUM_CH-1:0] ch_busy,
    input  logic              wr_en,
    input  logic [11:0]       addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic [DATA_W-1:0] grp_prio,
    output logic [DATA_W-1:0] arb_cfg
);
    logic [NUM_CLASS-1:0][NUM_CH-1:0] ev_all;
    logic [NUM_CLASS-1:0][NUM_CH-1:0] raw_all;
    logic [NUM_CLASS-1:0][NUM_CH-1:0] view_all;
    logic [NUM_CLASS-1:0]             raw_we;
    logic                             prio_we;
    logic                             arb_we;

    // Gather the event inputs in kind order.
    always_comb begin
        ev_all[EV_DONE]    = ev_done;
        ev_all[EV_SRC_ERR] = ev_src_err;
        ev_all[EV_DST_ERR] = ev_dst_err;
        ev_all[EV_CFG_ERR] = ev_cfg_err;
    end

    dma_irq_decode u_dec (
        .wr_en   (wr_en),
        .addr    (addr),
        .raw_we  (raw_we),
        .prio_we (prio_we),
        .arb_we  (arb_we)
    );

    for (genvar k = 0; k < NUM_CLASS; k++) begin : g_class
        dma_irq_class #(.NUM_CH(NUM_CH)) u_class (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev       (ev_all[k]),
            .clr_we   (raw_we[k]),
            .clr_bits (wdata[NUM_CH-1:0]),
            .en       (ch_irq_en),
            .raw_q    (raw_all[k]),
            .view     (view_all[k])
        );
    end

    dma_irq_rdmux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rd (
        .addr  (addr),
        .raw   (raw_all),
        .view  (view_all),
        .busy  (ch_busy),
        .rdata (rdata)
    );

    // Combined interrupt, one register after the enabled views.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |view_all;
    end

    // Write-only priority and arbitration settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_prio <= '0;
            arb_cfg  <= '0;
        end else begin
            if (prio_we) grp_prio <= wdata;
            if (arb_we)  arb_cfg  <= wdata;
        end
    end
endmodule

// File: rtl/dma_irq_chk.sv
`timescale 1ns/1ps
// Property checker for dma_irq_hub, attached by bind. Relates the
// event pulses, register accesses, read data and interrupt over time.
module dma_irq_chk
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [DATA_W-1:0]                wdata,
    input  logic [DATA_W-1:0]                rdata,
    input  logic [NUM_CH-1:0]                ch_irq_en,
    input  logic [NUM_CH-1:0]                ch_busy,
    input  logic                             irq,
    input  logic [DATA_W-1:0]                arb_cfg,
    input  logic [DATA_W-1:0]                grp_prio,
    input  logic [NUM_CLASS-1:0][NUM_CH-1:0] ev_all,
    input  logic [NUM_CLASS-1:0][NUM_CH-1:0] raw_all
);
    for (genvar k = 0; k < NUM_CLASS; k++) begin : g_k
        // R1 and R4: every pulsed bit is set after the edge.
        assert_event_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((raw_all[k] & $past(ev_all[k])) == $past(ev_all[k])));

        // R4: a clear that collides with an event leaves the bit set.
        assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == raw_addr(k) && |(wdata[NUM_CH-1:0] & ev_all[k]))
            |=> ((raw_all[k] & $past(wdata[NUM_CH-1:0] & ev_all[k]))
                 == $past(wdata[NUM_CH-1:0] & ev_all[k])));

        // R3: written ones without a new event are cleared.
        assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == raw_addr(k))
            |=> ((raw_all[k] & $past(wdata[NUM_CH-1:0] & ~ev_all[k])) == '0));

        // R5 and R10: without a write to its raw address, no bit drops.
        assert_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && addr == raw_addr(k))
            |=> ((raw_all[k] & $past(raw_all[k])) == $past(raw_all[k])));

        // R2: the enabled view read port applies the current enables.
        assert_view_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (addr == view_addr(k)) |-> (rdata == DATA_W'(raw_all[k] & ch_irq_en)));
    end

    // R6: the interrupt follows the enabled bits with one cycle of delay.
    assert_irq_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(raw_all[0] & ch_irq_en) | |(raw_all[1] & ch_irq_en)
                              | |(raw_all[2] & ch_irq_en) | |(raw_all[3] & ch_irq_en))));

    // R7: the busy mirror reads the live flags.
    assert_busy_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == BUSY_ADDR) |-> (rdata == DATA_W'(ch_busy)));

    // R8: write-only settings read back as zero and load on write.
    assert_wo_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == PRIO_ADDR || addr == ARB_ADDR) |-> (rdata == '0));
    assert_arb_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ARB_ADDR) |=> (arb_cfg == $past(wdata)));
    assert_prio_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == PRIO_ADDR) |=> (grp_prio == $past(wdata)));
endmodule

bind dma_irq_hub dma_irq_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .ch_irq_en (ch_irq_en),
    .ch_busy   (ch_busy),
    .irq       (irq),
    .arb_cfg   (arb_cfg),
    .grp_prio  (grp_prio),
    .ev_all    (ev_all),
    .raw_all   (raw_all)
);

// File: tb/dma_irq_hub_test.sv
`timescale 1ns/1ps
// Bench for dma_irq_hub: directed corner cases, then seeded random
// traffic, all compared with a model built from the requirements.
module dma_irq_hub_test;
    localparam int N  = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  ev_done = '0, ev_src_err = '0, ev_dst_err = '0, ev_cfg_err = '0;
    logic [N-1:0]  ch_irq_en = '0, ch_busy = '0;
    logic          wr_en = 1'b0;
    logic [11:0]   addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata, grp_prio, arb_cfg;
    logic          irq;

    int checks = 0;
    int errors = 0;

    logic [3:0][N-1:0] m_raw = '0;
    logic              m_irq = 1'b0;
    logic [DW-1:0]     m_prio = '0, m_arb = '0;

    dma_irq_hub #(.NUM_CH(N), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .ev_done(ev_done), .ev_src_err(ev_src_err),
        .ev_dst_err(ev_dst_err), .ev_cfg_err(ev_cfg_err),
        .ch_irq_en(ch_irq_en), .ch_busy(ch_busy),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq(irq), .grp_prio(grp_prio), .arb_cfg(arb_cfg)
    );

    always #10 clk = ~clk;

    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [DW-1:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    // Compare every readable view and output with the model.
    task automatic verify(input string tag);
        for (int k = 0; k < 4; k++) begin
            rd({tag, " raw R1"}, 12'h810 + 12'(4 * k), DW'(m_raw[k]));
            rd({tag, " view R2"}, 12'h800 + 12'(4 * k), DW'(m_raw[k] & ch_irq_en));
        end
        rd({tag, " busy R7"}, 12'h820, DW'(ch_busy));
        rd({tag, " prio rd R8"}, 12'h824, '0);
        rd({tag, " arb rd R8"}, 12'h828, '0);
        chk({tag, " irq R6"}, DW'(irq), DW'(m_irq));
        chk({tag, " prio R8"}, grp_prio, m_prio);
        chk({tag, " arb R8"}, arb_cfg, m_arb);
    endtask

    // Drive one cycle of stimulus, update the model, pass the edge.
    task automatic step(input logic [3:0][N-1:0] ev, input logic [N-1:0] en,
                        input logic [N-1:0] busy, input logic we,
                        input logic [11:0] a, input logic [DW-1:0] d);
        logic nxt_irq;
        ev_done = ev[0]; ev_src_err = ev[1]; ev_dst_err = ev[2]; ev_cfg_err = ev[3];
        ch_irq_en = en; ch_busy = busy;
        wr_en = we; addr = a; wdata = d;
        nxt_irq = 1'b0;
        for (int k = 0; k < 4; k++) nxt_irq = nxt_irq | (|(m_raw[k] & en));
        for (int k = 0; k < 4; k++) begin
            if (we && a == 12'h810 + 12'(4 * k)) m_raw[k] = m_raw[k] & ~d[N-1:0];
            m_raw[k] = m_raw[k] | ev[k];
        end
        if (we && a == 12'h824) m_prio = d;
        if (we && a == 12'h828) m_arb = d;
        @(posedge clk);
        #1;
        m_irq = nxt_irq;
        ev_done = '0; ev_src_err = '0; ev_dst_err = '0; ev_cfg_err = '0;
        wr_en = 1'b0;
    endtask

    function automatic logic [3:0][N-1:0] evs(input logic [N-1:0] a, input logic [N-1:0] b,
                                              input logic [N-1:0] c, input logic [N-1:0] e);
        logic [3:0][N-1:0] r;
        r[0] = a; r[1] = b; r[2] = c; r[3] = e;
        return r;
    endfunction

    initial begin
        logic [N-1:0] en_r, busy_r;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R9: reset state everywhere.
        verify("reset R9");

        // R1: one event of each kind on a different channel.
        step(evs(4'h1, 4'h2, 4'h4, 4'h8), 4'hF, 4'h0, 1'b0, 12'h0, '0);
        rd("done raw R1", 12'h810, 32'h1);
        rd("cfg raw R1", 12'h81C, 32'h8);
        verify("events R1");

        // R2: partial enables mask the view only.
        step(evs(0, 0, 0, 0), 4'b0101, 4'h0, 1'b0, 12'h0, '0);
        rd("src view masked R2", 12'h804, 32'h0);
        rd("src raw kept R2", 12'h814, 32'h2);
        chk("irq set R6", DW'(irq), 32'h1);
        verify("mask R2");

        // R3: zero write keeps bits; ones clear only one kind (R5).
        step(evs(0, 0, 0, 0), 4'hF, 4'h0, 1'b1, 12'h810, 32'h0);
        rd("zero write R3", 12'h810, 32'h1);
        step(evs(0, 0, 0, 0), 4'hF, 4'h0, 1'b1, 12'h814, 32'hFFFF_FFFF);
        rd("src cleared R3", 12'h814, 32'h0);
        rd("dst untouched R5", 12'h818, 32'h4);
        verify("w1c R3 R5");

        // R4: clear and new event on the same bit in one cycle.
        step(evs(4'h4, 0, 0, 0), 4'hF, 4'h0, 1'b1, 12'h810, 32'h5);
        rd("collision R4", 12'h810, 32'h4);
        verify("collision R4");

        // R10: writes to view or unmapped addresses change nothing.
        step(evs(0, 0, 0, 0), 4'hF, 4'h0, 1'b1, 12'h800, 32'hFFFF_FFFF);
        step(evs(0, 0, 0, 0), 4'hF, 4'h0, 1'b1, 12'h830, 32'hFFFF_FFFF);
        rd("unmapped read R10", 12'h830, 32'h0);
        rd("done kept R10", 12'h810, 32'h4);
        verify("ignored R10");

        // R7: busy mirror.
        step(evs(0, 0, 0, 0), 4'hF, 4'b1010, 1'b0, 12'h0, '0);
        rd("busy R7", 12'h820, 32'hA);

        // R8: priority and arbitration settings, then back to equal.
        step(evs(0, 0, 0, 0), 4'hF, 4'h0, 1'b1, 12'h824, 32'h0000_005A);
        step(evs(0, 0, 0, 0), 4'hF, 4'h0, 1'b1, 12'h828, 32'h0000_0003);
        chk("arb load R8", arb_cfg, 32'h3);
        chk("prio load R8", grp_prio, 32'h5A);
        step(evs(0, 0, 0, 0), 4'hF, 4'h0, 1'b1, 12'h828, 32'h0);
        chk("arb equal R8", arb_cfg, 32'h0);
        verify("ctrl R8");

        // R3 and R6: clear every channel of every kind; irq drops one edge later.
        for (int k = 0; k < 4; k++)
            step(evs(0, 0, 0, 0), 4'hF, 4'h0, 1'b1, 12'h810 + 12'(4 * k), 32'hFFFF_FFFF);
        step(evs(0, 0, 0, 0), 4'hF, 4'h0, 1'b0, 12'h0, '0);
        chk("irq cleared R6", DW'(irq), 32'h0);
        verify("clear all R3");

        // Random traffic: sparse events, writes mostly to raw addresses.
        for (int i = 0; i < 400; i++) begin
            logic [3:0][N-1:0] ev;
            logic [11:0] a;
            logic we;
            logic [DW-1:0] d;
            for (int k = 0; k < 4; k++) ev[k] = N'($urandom & $urandom & $urandom);
            en_r = N'($urandom);
            busy_r = N'($urandom);
            we = ($urandom % 3) != 0;
            case ($urandom % 8)
                0: a = 12'h800 + 12'(4 * ($urandom % 4));
                1: a = 12'h824;
                2: a = 12'h828;
                3: a = 12'h83C;
                default: a = 12'h810 + 12'(4 * ($urandom % 4));
            endcase
            d = (($urandom % 4) == 0) ? 32'hFFFF_FFFF : $urandom;
            step(ev, en_r, busy_r, we, a, d);
            verify("random R1 R3 R4 R5 R10");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule